// File: doc/BRIEF.md
# Oversampling Serial Receiver with Overrun Detection

This block is the receive half of a serial controller. It watches a single serial input line and, on every pulse of a receive-rate tick, decides whether to look at the line. The rate factor is chosen at run time from three settings: one tick per bit, sixteen ticks per bit, or sixty-four ticks per bit. In the oversampled settings a falling edge is checked again halfway into the start bit, so a short glitch does not start a character. Data bits are sampled once per bit period, nominally at the bit centre, and are shifted in least significant bit first. An optional parity bit follows the data, and the last bit is a single stop bit.

When the stop bit has been sampled, the assembled character moves into a holding register and a ready flag is raised for the host. A host read strobe lowers the flag. If another character completes while the flag is still up, the newer character replaces the older one and a sticky overrun flag is set. Parity and framing errors are also sticky, and a single error-clear strobe clears all three flags. Reception only runs while the receive-enable input is high. Dropping the enable abandons any character that is partly received.

Top module: `serial_rx`

## Requirements
- R1: After reset, rxReady, parityErr, frameErr and overrunErr are 0 and rxData is all zeros.
- R2: A character is a low start bit, then DATA_W data bits sent least significant bit first, then an optional parity bit, then one stop bit, with the line idling high. After the stop bit is sampled, rxData holds the data bits and rxReady is 1.
- R3: rateSel selects the number of rxTick pulses per bit. 2'b00 gives 1 (start detected on the first tick that sees the line low). 2'b01 gives 16. 2'b10 and 2'b11 give 64. Each later bit is sampled that many ticks after the previous sample.
- R4: With 16 or 64 ticks per bit, a low level that is high again when the line is rechecked, half a bit period after the start was detected, is ignored and delivers no character.
- R5: When parityEn is 1, a parity bit follows the data. parityOdd=0 requires an even count of ones over the data and parity bits, and parityOdd=1 requires an odd count. A mismatch sets parityErr.
- R6: A stop bit sampled low sets frameErr, and the character is still delivered to rxData with rxReady set.
- R7: A one-cycle hostRead pulse clears rxReady.
- R8: If a character completes while rxReady is 1 and hostRead is 0, overrunErr is set and rxData takes the newer character.
- R9: parityErr, frameErr and overrunErr stay set until a one-cycle errReset pulse, which clears all three.
- R10: While rxEnable is 0, no character is received. A character in progress is discarded, and rxReady and rxData keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxTick | input | 1 | One-cycle pulse per receive clock period |
| rxLine | input | 1 | Serial receive line, idle high |
| rxEnable | input | 1 | Receive enable |
| rateSel | input | 2 | Ticks-per-bit select (00 x1, 01 x16, 1x x64) |
| parityEn | input | 1 | A parity bit follows the data bits |
| parityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| hostRead | input | 1 | Host read strobe, clears rxReady |
| errReset | input | 1 | Clears the three error flags |
| rxData | output | DATA_W | Holding register with the last received character |
| rxReady | output | 1 | A character is waiting to be read |
| parityErr | output | 1 | Sticky parity error |
| frameErr | output | 1 | Sticky framing error |
| overrunErr | output | 1 | Sticky overrun error |

## Verification
The bench drives characters at all three rate factors, using bit patterns whose ends differ, so that a receiver that assembles bits in the wrong order or samples one bit late delivers a wrong byte. A short low pulse probes the mid-start recheck: a receiver without the recheck would deliver a spurious all-ones character. Two characters are sent without a read between them. A design that failed to overwrite the held byte, or to set the overrun flag, shows a stale byte or a clear flag. A later clean character confirms that the flag is sticky. Characters with a flipped parity bit or a low stop bit, and a character sent while reception is disabled, check that errors are flagged and that disabled traffic leaves rxReady and rxData untouched.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int MAX_FACTOR = 64;
  localparam int CNT_W = $clog2(MAX_FACTOR + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rxStateT;

  // strobes from control to datapath, all qualified by a tick
  typedef struct packed {
    logic clearAcc;  // start accepted, reset shift/parity accumulators
    logic shiftIn;   // sample one data bit
    logic checkPar;  // sample the parity bit
    logic finish;    // sample the stop bit and deliver the character
  } rxStrobeT;

  function automatic logic [CNT_W-1:0] ticksPerBit(input logic [1:0] sel);
    case (sel)
      2'b00:   ticksPerBit = CNT_W'(1);
      2'b01:   ticksPerBit = CNT_W'(16);
      default: ticksPerBit = CNT_W'(MAX_FACTOR);
    endcase
  endfunction

endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       line,
  input  logic       enable,
  input  logic [1:0] rateSel,
  input  logic       parityEn,
  output rxStrobeT   strobe
);

  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  rxStateT           state;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitIdx;
  logic [CNT_W-1:0]  factor;
  logic [CNT_W-1:0]  halfFactor;
  logic              step;
  logic              atSample;

  always_comb begin
    factor     = ticksPerBit(rateSel);
    halfFactor = factor >> 1;
    step       = tick && enable;
    atSample   = (cnt == factor);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (!enable) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          if (!line) begin
            cnt    <= CNT_W'(1);
            bitIdx <= '0;
            state  <= (factor == CNT_W'(1)) ? ST_DATA : ST_START;
          end
        end
        ST_START: begin
          if (cnt == halfFactor) begin
            cnt    <= CNT_W'(1);
            bitIdx <= '0;
            state  <= line ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (atSample) begin
            cnt <= CNT_W'(1);
            if (bitIdx == BIT_W'(DATA_W - 1)) begin
              state <= parityEn ? ST_PARITY : ST_STOP;
            end
            bitIdx <= bitIdx + BIT_W'(1);
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_PARITY: begin
          if (atSample) begin
            cnt   <= CNT_W'(1);
            state <= ST_STOP;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_STOP: begin
          if (atSample) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.clearAcc = step && (state == ST_IDLE) && !line;
    strobe.shiftIn  = step && (state == ST_DATA) && atSample;
    strobe.checkPar = step && (state == ST_PARITY) && atSample;
    strobe.finish   = step && (state == ST_STOP) && atSample;
  end

  AST_DISABLE_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (state == ST_IDLE)); // R10

  AST_FALSE_START_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && step && cnt == halfFactor && line) |=> (state == ST_IDLE)); // R4

  AST_NO_START_IN_X1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && step && !line && rateSel == 2'b00) |=> (state == ST_DATA)); // R3

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.shiftIn, strobe.checkPar, strobe.finish})); // R2

endmodule

// File: rtl/serial_rx_dp.sv
module serial_rx_dp
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              line,
  input  rxStrobeT          strobe,
  input  logic              parityOdd,
  input  logic              hostRead,
  input  logic              errReset,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              parityErr,
  output logic              frameErr,
  output logic              overrunErr
);

  logic [DATA_W-1:0] shiftReg;
  logic              parAcc;

  // assembly: new bits enter at the top so the first bit ends at bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
    end else if (strobe.clearAcc) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
    end else if (strobe.shiftIn) begin
      shiftReg <= {line, shiftReg[DATA_W-1:1]};
      parAcc   <= parAcc ^ line;
    end
  end

  // holding register and ready flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxReady <= 1'b0;
    end else if (strobe.finish) begin
      rxData  <= shiftReg;
      rxReady <= 1'b1;
    end else if (hostRead) begin
      rxReady <= 1'b0;
    end
  end

  // sticky error flags, setting wins over clearing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      if (strobe.checkPar && ((parAcc ^ line) != parityOdd)) begin
        parityErr <= 1'b1;
      end else if (errReset) begin
        parityErr <= 1'b0;
      end
      if (strobe.finish && !line) begin
        frameErr <= 1'b1;
      end else if (errReset) begin
        frameErr <= 1'b0;
      end
      if (strobe.finish && rxReady && !hostRead) begin
        overrunErr <= 1'b1;
      end else if (errReset) begin
        overrunErr <= 1'b0;
      end
    end
  end

  AST_READY_ON_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> rxReady); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> $stable(rxData)); // R10

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (hostRead && !strobe.finish) |=> !rxReady); // R7

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && rxReady && !hostRead) |=> overrunErr); // R8

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!errReset && (parityErr || frameErr || overrunErr))
      |=> ((parityErr || !$past(parityErr)) && (frameErr || !$past(frameErr))
           && (overrunErr || !$past(overrunErr)))); // R9

  AST_CLEAR_FRAME_OVR: assert property (@(posedge clk) disable iff (!rstN)
    (errReset && !strobe.finish) |=> (!frameErr && !overrunErr)); // R9

  AST_CLEAR_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    (errReset && !strobe.checkPar) |=> !parityErr); // R9

endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxTick,
  input  logic              rxLine,
  input  logic              rxEnable,
  input  logic [1:0]        rateSel,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              hostRead,
  input  logic              errReset,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              parityErr,
  output logic              frameErr,
  output logic              overrunErr
);

  rxStrobeT strobe;

  serial_rx_ctrl #(.DATA_W(DATA_W)) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (rxTick),
    .line     (rxLine),
    .enable   (rxEnable),
    .rateSel  (rateSel),
    .parityEn (parityEn),
    .strobe   (strobe)
  );

  serial_rx_dp #(.DATA_W(DATA_W)) dp (
    .clk        (clk),
    .rstN       (rstN),
    .line       (rxLine),
    .strobe     (strobe),
    .parityOdd  (parityOdd),
    .hostRead   (hostRead),
    .errReset   (errReset),
    .rxData     (rxData),
    .rxReady    (rxReady),
    .parityErr  (parityErr),
    .frameErr   (frameErr),
    .overrunErr (overrunErr)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!rxReady && !overrunErr)); // R1

endmodule

// File: tb/serial_rx_test.sv
`timescale 1ns/1ps
module serial_rx_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxTick = 1'b0;
  logic       rxLine = 1'b1;
  logic       rxEnable = 1'b0;
  logic [1:0] rateSel = 2'b01;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       hostRead = 1'b0;
  logic       errReset = 1'b0;
  logic [7:0] rxData;
  logic       rxReady;
  logic       parityErr;
  logic       frameErr;
  logic       overrunErr;

  int checks = 0;
  int errors = 0;
  bit autoRead = 1'b0;
  bit done = 1'b0;
  logic [1:0] divCnt = '0;

  typedef struct {
    logic [7:0] d;
    logic       pe;
    logic       fe;
  } expT;
  expT expQ[$];

  serial_rx #(.DATA_W(8)) uut (
    .clk(clk), .rstN(rstN), .rxTick(rxTick), .rxLine(rxLine),
    .rxEnable(rxEnable), .rateSel(rateSel), .parityEn(parityEn),
    .parityOdd(parityOdd), .hostRead(hostRead), .errReset(errReset),
    .rxData(rxData), .rxReady(rxReady), .parityErr(parityErr),
    .frameErr(frameErr), .overrunErr(overrunErr)
  );

  always #5 clk = ~clk;

  // one tick every four clocks, changed away from the active edge
  always @(negedge clk) begin
    divCnt <= divCnt + 2'd1;
    rxTick <= (divCnt == 2'd3);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!rxTick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  // driver: pushes the expected item, then serialises the character
  task automatic sendChar(input logic [7:0] d, input int f, input bit badPar,
                          input bit badStop, input bit push);
    expT e;
    if (push) begin
      e.d  = d;
      e.pe = parityEn && badPar;
      e.fe = badStop;
      expQ.push_back(e);
    end
    rxLine = 1'b0;
    waitTicks(f);
    for (int b = 0; b < 8; b++) begin
      rxLine = d[b];
      waitTicks(f);
    end
    if (parityEn) begin
      rxLine = (^d) ^ parityOdd ^ badPar;
      waitTicks(f);
    end
    rxLine = !badStop;
    waitTicks(f);
    rxLine = 1'b1;
    waitTicks(f + 2);
  endtask

  // monitor: pops and compares each delivered character, then reads it
  initial begin
    expT e;
    forever begin
      @(negedge clk);
      if (autoRead && rxReady) begin
        if (expQ.size() == 0) begin
          chk("R4 unexpected character", {24'd0, rxData}, 32'hFFFF_FFFF);
        end else begin
          e = expQ.pop_front();
          chk("R2 R3 data", {24'd0, rxData}, {24'd0, e.d});
          chk("R5 parity flag", {31'd0, parityErr}, {31'd0, e.pe});
          chk("R6 frame flag", {31'd0, frameErr}, {31'd0, e.fe});
        end
        hostRead = 1'b1;
        errReset = e.pe | e.fe;
        @(negedge clk);
        hostRead = 1'b0;
        errReset = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 rxReady", {31'd0, rxReady}, 32'd0);
    chk("R1 rxData", {24'd0, rxData}, 32'd0);
    chk("R1 flags", {29'd0, parityErr, frameErr, overrunErr}, 32'd0);
    rstN = 1'b1;
    rxEnable = 1'b1;
    autoRead = 1'b1;
    waitTicks(3);

    // R2 R3: x16, x1, x64 with distinct patterns
    rateSel = 2'b01;
    sendChar(8'hA5, 16, 0, 0, 1);
    sendChar(8'h01, 16, 0, 0, 1);
    sendChar(8'h80, 16, 0, 0, 1);
    rateSel = 2'b00;
    sendChar(8'h3C, 1, 0, 0, 1);
    sendChar(8'hC1, 1, 0, 0, 1);
    rateSel = 2'b10;
    sendChar(8'h96, 64, 0, 0, 1);
    rateSel = 2'b11;
    sendChar(8'h4E, 64, 0, 0, 1);

    // R4 false start: short low pulse in x16, then a real character
    rateSel = 2'b01;
    rxLine = 1'b0;
    waitTicks(4);
    rxLine = 1'b1;
    waitTicks(40);
    chk("R4 no character after glitch", {31'd0, rxReady}, 32'd0);
    sendChar(8'h5A, 16, 0, 0, 1);

    // R5 parity: even good, even bad, odd good, odd bad
    parityEn = 1'b1;
    parityOdd = 1'b0;
    sendChar(8'h07, 16, 0, 0, 1);
    sendChar(8'h07, 16, 1, 0, 1);
    parityOdd = 1'b1;
    sendChar(8'hF0, 16, 0, 0, 1);
    sendChar(8'hF0, 16, 1, 0, 1);
    parityEn = 1'b0;
    parityOdd = 1'b0;

    // R6 framing error, character still delivered
    sendChar(8'h6D, 16, 0, 1, 1);

    chk("R2 scoreboard drained", expQ.size(), 32'd0);

    // R8 overrun and R7 read, with manual reads
    autoRead = 1'b0;
    sendChar(8'h11, 16, 0, 0, 0);
    chk("R2 first held", {24'd0, rxData}, 32'h11);
    chk("R8 no overrun yet", {31'd0, overrunErr}, 32'd0);
    sendChar(8'h22, 16, 0, 0, 0);
    chk("R8 newer replaces older", {24'd0, rxData}, 32'h22);
    chk("R8 overrun set", {31'd0, overrunErr}, 32'd1);
    hostRead = 1'b1;
    @(negedge clk);
    hostRead = 1'b0;
    chk("R7 read clears ready", {31'd0, rxReady}, 32'd0);

    // R9 sticky across a clean character, then cleared
    sendChar(8'h33, 16, 0, 0, 0);
    chk("R9 overrun sticky", {31'd0, overrunErr}, 32'd1);
    hostRead = 1'b1;
    errReset = 1'b1;
    @(negedge clk);
    hostRead = 1'b0;
    errReset = 1'b0;
    chk("R9 flags cleared", {29'd0, parityErr, frameErr, overrunErr}, 32'd0);

    // R10 disabled: character ignored, holding state kept
    rxEnable = 1'b0;
    sendChar(8'hE7, 16, 0, 0, 0);
    chk("R10 ready stays low", {31'd0, rxReady}, 32'd0);
    chk("R10 data unchanged", {24'd0, rxData}, 32'h33);
    // R10 disable mid-character discards it
    rxEnable = 1'b1;
    rxLine = 1'b0;
    waitTicks(40);
    rxEnable = 1'b0;
    rxLine = 1'b1;
    waitTicks(150);
    rxEnable = 1'b1;
    waitTicks(20);
    chk("R10 aborted char not delivered", {31'd0, rxReady}, 32'd0);
    chk("R10 data kept after abort", {24'd0, rxData}, 32'h33);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule